// File: doc/BRIEF.md
# Indirect Command/Status Register Front End

This block is the host-facing register front end of a network controller. The host sees only two 16-bit word locations on a small bus. One location holds a register pointer. The other is a window onto whichever internal register that pointer selects. Register 0 of the internal file is the command/status word. Host writes to it stop, initialise or start the controller's engines. It also collects interrupt flags from the receive and transmit engines and drives one level-sensitive interrupt line.

The separate receive and transmit engines each report with one-cycle pulses: frame received, frame sent, and transmit timeout (babble). Each pulse sets a sticky flag in register 0. The host reads the flags through the data window and clears them by writing ones. The engines take their run enables from two outputs that follow the receiver-on and transmitter-on bits. Registers 1 to NREGS-1 are plain read/write storage for the engines' configuration.

Register 0 bit layout: INIT bit 0, START bit 1, STOP bit 2, TXON bit 4, RXON bit 5, INEA (interrupt enable) bit 6, INTR (interrupt summary) bit 7, IDON (init done) bit 8, TINT bit 9, RINT bit 10, BABL bit 14, ERR (error summary) bit 15. All other bits read as zero.

Top module: `iacsr_top`

## Requirements
- R1: A bus write at word offset 1 stores the value in the pointer register, and a read at offset 1 returns it. A read or write at offset 0 reaches the internal register whose index equals the pointer.
- R2: A write to register 0 with STOP (bit 2) set leaves register 0 reading exactly 0x0004. This holds whatever other bits are written and whatever engine pulses arrive in the same cycle.
- R3: A write to register 0 with INIT (bit 0) set and STOP clear sets INIT and IDON (bit 8) and clears STOP. INIT takes precedence over START, so START is not applied in that write.
- R4: A write to register 0 with START (bit 1) set and both STOP and INIT clear sets START, RXON (bit 5) and TXON (bit 4) and clears STOP. Outputs run_rx and run_tx follow RXON and TXON.
- R5: A pulse on rx_done sets RINT (bit 10), a pulse on tx_done sets TINT (bit 9), and a pulse on tx_babble sets BABL (bit 14). A pulse wins over a write-one-to-clear of the same flag in the same cycle.
- R6: INTR (bit 7) reads as 1 exactly when any of RINT, TINT, IDON or BABL is set. irq_out is high exactly when INEA (bit 6) and INTR are both 1.
- R7: A register-0 write without STOP clears each of RINT, TINT, IDON and BABL whose bit is written as 1. It loads INEA from bit 6. It leaves INIT, START, RXON and TXON unchanged when their bits are written as 0.
- R8: ERR (bit 15) reads as 1 exactly while BABL is set.
- R9: Offsets 2 and 3 read as zero and writes to them change nothing. A pointer value of NREGS or more makes the data window read zero and ignore writes. Registers 1 to NREGS-1 return what was last written to them.
- R10: After the synchronous active-low reset, register 0 reads 0x0004, the pointer reads 0, the storage registers read 0, and irq_out is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_off | input | OFF_W | Word offset: 0 data window, 1 pointer |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational, zero when no read) |
| rx_done | input | 1 | Receive-complete pulse |
| tx_done | input | 1 | Transmit-complete pulse |
| tx_babble | input | 1 | Transmit-timeout pulse |
| run_rx | output | 1 | Receiver run enable (RXON) |
| run_tx | output | 1 | Transmitter run enable (TXON) |
| irq_out | output | 1 | Level interrupt request |

## Verification
Register 0 is written with command words that contain one command bit, two command bits, and all three. Comparing the results separates a correct STOP > INIT > START priority from a wrong ordering or from OR-merging the commands. Engine pulses are applied with the interrupt enable both on and off, which separates the gating of irq_out from the INTR summary. One pulse arrives in the same cycle as a write-one-to-clear of its flag, and one arrives during a STOP write; these show which write/event precedence was built. Pointer values inside and beyond the register file, and the unused offsets, show whether the decode has gaps or aliases.

// File: rtl/iacsr_pkg.sv
package iacsr_pkg;

  localparam int DATA_W = 16;

  // register-0 bit positions
  localparam int B_INIT  = 0;
  localparam int B_START = 1;
  localparam int B_STOP  = 2;
  localparam int B_TXON  = 4;
  localparam int B_RXON  = 5;
  localparam int B_INEA  = 6;
  localparam int B_INTR  = 7;
  localparam int B_IDON  = 8;
  localparam int B_TINT  = 9;
  localparam int B_RINT  = 10;
  localparam int B_BABL  = 14;
  localparam int B_ERR   = 15;

  typedef struct packed {
    logic babl;
    logic idon;
    logic tint;
    logic rint;
    logic inea;
    logic rxon;
    logic txon;
    logic stop;
    logic start;
    logic init;
  } csr0_t;

  function automatic csr0_t csr0_stopped();
    csr0_t n;
    n = '0;
    n.stop = 1'b1;
    return n;
  endfunction

  function automatic logic csr0_pending(csr0_t s);
    return s.rint | s.tint | s.idon | s.babl;
  endfunction

  function automatic logic [DATA_W-1:0] csr0_word(csr0_t s);
    logic [DATA_W-1:0] w;
    w = '0;
    w[B_INIT]  = s.init;
    w[B_START] = s.start;
    w[B_STOP]  = s.stop;
    w[B_TXON]  = s.txon;
    w[B_RXON]  = s.rxon;
    w[B_INEA]  = s.inea;
    w[B_INTR]  = csr0_pending(s);
    w[B_IDON]  = s.idon;
    w[B_TINT]  = s.tint;
    w[B_RINT]  = s.rint;
    w[B_BABL]  = s.babl;
    w[B_ERR]   = s.babl;
    return w;
  endfunction

  // host write to register 0: STOP beats INIT beats START
  function automatic csr0_t csr0_cmd(csr0_t s, logic [DATA_W-1:0] v);
    csr0_t n;
    n = s;
    if (v[B_STOP]) begin
      n = csr0_stopped();
    end else begin
      if (v[B_RINT]) n.rint = 1'b0;
      if (v[B_TINT]) n.tint = 1'b0;
      if (v[B_IDON]) n.idon = 1'b0;
      if (v[B_BABL]) n.babl = 1'b0;
      n.inea = v[B_INEA];
      if (v[B_INIT]) begin
        n.init = 1'b1;
        n.idon = 1'b1;
        n.stop = 1'b0;
      end else if (v[B_START]) begin
        n.start = 1'b1;
        n.rxon  = 1'b1;
        n.txon  = 1'b1;
        n.stop  = 1'b0;
      end
    end
    return n;
  endfunction

  function automatic csr0_t csr0_events(csr0_t s, logic rx, logic tx, logic bab);
    csr0_t n;
    n = s;
    if (rx)  n.rint = 1'b1;
    if (tx)  n.tint = 1'b1;
    if (bab) n.babl = 1'b1;
    return n;
  endfunction

endpackage

// File: rtl/iacsr_port_dec.sv
module iacsr_port_dec #(
  parameter int OFF_W = 2
) (
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [OFF_W-1:0] bus_off,
  output logic             wr_data,
  output logic             wr_ptr,
  output logic             rd_data,
  output logic             rd_ptr
);
  localparam logic [OFF_W-1:0] OFF_DATA = OFF_W'(0);
  localparam logic [OFF_W-1:0] OFF_PTR  = OFF_W'(1);

  logic hit_data;
  logic hit_ptr;

  assign hit_data = (bus_off == OFF_DATA);
  assign hit_ptr  = (bus_off == OFF_PTR);

  assign wr_data = bus_sel &  bus_we & hit_data;
  assign wr_ptr  = bus_sel &  bus_we & hit_ptr;
  assign rd_data = bus_sel & ~bus_we & hit_data;
  assign rd_ptr  = bus_sel & ~bus_we & hit_ptr;
endmodule

// File: rtl/iacsr_ptr_reg.sv
module iacsr_ptr_reg
  import iacsr_pkg::*;
#(
  parameter int NREGS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ptr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ptr_q,
  output logic              sel_csr0,
  output logic              sel_valid
);
  localparam logic [DATA_W-1:0] LIMIT = DATA_W'(NREGS);

  always_ff @(posedge clk) begin
    if (!rst_n)      ptr_q <= '0;
    else if (wr_ptr) ptr_q <= wdata;
  end

  assign sel_csr0  = (ptr_q == '0);
  assign sel_valid = (ptr_q < LIMIT);
endmodule

// File: rtl/iacsr_csr0.sv
module iacsr_csr0
  import iacsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_csr0,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rx_done,
  input  logic              tx_done,
  input  logic              tx_babble,
  output logic [DATA_W-1:0] csr0_word_o,
  output logic              run_rx,
  output logic              run_tx,
  output logic              irq
);
  csr0_t st_q;
  csr0_t st_cmd;
  csr0_t st_d;
  logic  stop_wr;

  assign stop_wr = wr_csr0 & wdata[B_STOP];

  always_comb begin
    st_cmd = wr_csr0 ? csr0_cmd(st_q, wdata) : st_q;
    st_d   = stop_wr ? st_cmd : csr0_events(st_cmd, rx_done, tx_done, tx_babble);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= csr0_stopped();
    else        st_q <= st_d;
  end

  assign csr0_word_o = csr0_word(st_q);
  assign run_rx      = st_q.rxon;
  assign run_tx      = st_q.txon;
  assign irq         = st_q.inea & csr0_pending(st_q);
endmodule

// File: rtl/iacsr_bank.sv
module iacsr_bank
  import iacsr_pkg::*;
#(
  parameter int NREGS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data,
  input  logic [DATA_W-1:0] ptr_q,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_word
);
  logic [DATA_W-1:0] bank_q [NREGS];

  assign bank_q[0] = '0;

  for (genvar g = 1; g < NREGS; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                 q <= '0;
      else if (wr_data && ptr_q == DATA_W'(g))    q <= wdata;
    end
    assign bank_q[g] = q;
  end

  always_comb begin
    rd_word = '0;
    for (int i = 1; i < NREGS; i++) begin
      if (ptr_q == DATA_W'(i)) rd_word = bank_q[i];
    end
  end
endmodule

// File: rtl/iacsr_top.sv
module iacsr_top
  import iacsr_pkg::*;
#(
  parameter int NREGS = 4,
  parameter int OFF_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [OFF_W-1:0]  bus_off,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_done,
  input  logic              tx_done,
  input  logic              tx_babble,
  output logic              run_rx,
  output logic              run_tx,
  output logic              irq_out
);
  logic              wr_data, wr_ptr, rd_data, rd_ptr;
  logic [DATA_W-1:0] ptr_q;
  logic              sel_csr0, sel_valid;
  logic              wr_csr0, wr_bank;
  logic [DATA_W-1:0] csr0_word_q;
  logic [DATA_W-1:0] bank_word;

  iacsr_port_dec #(.OFF_W(OFF_W)) u_dec (
    .bus_sel (bus_sel),
    .bus_we  (bus_we),
    .bus_off (bus_off),
    .wr_data (wr_data),
    .wr_ptr  (wr_ptr),
    .rd_data (rd_data),
    .rd_ptr  (rd_ptr)
  );

  iacsr_ptr_reg #(.NREGS(NREGS)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ptr    (wr_ptr),
    .wdata     (bus_wdata),
    .ptr_q     (ptr_q),
    .sel_csr0  (sel_csr0),
    .sel_valid (sel_valid)
  );

  assign wr_csr0 = wr_data & sel_csr0;
  assign wr_bank = wr_data & sel_valid & ~sel_csr0;

  iacsr_csr0 u_csr0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_csr0     (wr_csr0),
    .wdata       (bus_wdata),
    .rx_done     (rx_done),
    .tx_done     (tx_done),
    .tx_babble   (tx_babble),
    .csr0_word_o (csr0_word_q),
    .run_rx      (run_rx),
    .run_tx      (run_tx),
    .irq         (irq_out)
  );

  iacsr_bank #(.NREGS(NREGS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_data (wr_bank),
    .ptr_q   (ptr_q),
    .wdata   (bus_wdata),
    .rd_word (bank_word)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_ptr) begin
      bus_rdata = ptr_q;
    end else if (rd_data && sel_valid) begin
      bus_rdata = sel_csr0 ? csr0_word_q : bank_word;
    end
  end
endmodule

// File: rtl/iacsr_chk.sv
module iacsr_chk
  import iacsr_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [OFF_W-1:0]  bus_off,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              rx_done,
  input logic              tx_babble,
  input logic              irq_out,
  input logic              wr_csr0,
  input logic [DATA_W-1:0] csr0_word_q,
  input logic [DATA_W-1:0] ptr_q
);
  logic ptr_write;
  logic stop_write;
  assign ptr_write  = bus_sel && bus_we && (bus_off == OFF_W'(1));
  assign stop_write = wr_csr0 && bus_wdata[B_STOP];

  p_ptr_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_write |=> ptr_q == $past(bus_wdata));
  p_ptr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_write |=> $stable(ptr_q));
  p_stop_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_write |=> csr0_word_q == 16'h0004);
  p_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_csr0 && !bus_wdata[B_STOP] && bus_wdata[B_INIT])
      |=> (csr0_word_q[B_INIT] && csr0_word_q[B_IDON] && !csr0_word_q[B_STOP]));
  p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_csr0 && bus_wdata[2:0] == 3'b010)
      |=> (csr0_word_q[B_START] && csr0_word_q[B_RXON] && csr0_word_q[B_TXON]
           && !csr0_word_q[B_STOP]));
  p_rx_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !stop_write) |=> (csr0_word_q[B_RINT] && csr0_word_q[B_INTR]));
  p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (csr0_word_q[B_INEA] && csr0_word_q[B_INTR]));
  p_err_summary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_babble && !stop_write) |=> csr0_word_q[B_ERR]);
  p_undef_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_off > OFF_W'(1)) |-> bus_rdata == '0);
endmodule

bind iacsr_top iacsr_chk #(.OFF_W(OFF_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel     (bus_sel),
  .bus_we      (bus_we),
  .bus_off     (bus_off),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .rx_done     (rx_done),
  .tx_babble   (tx_babble),
  .irq_out     (irq_out),
  .wr_csr0     (wr_csr0),
  .csr0_word_q (csr0_word_q),
  .ptr_q       (ptr_q)
);

// File: tb/test_iacsr_top.sv
module test_iacsr_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_off = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        rx_done = 1'b0, tx_done = 1'b0, tx_babble = 1'b0;
  logic        run_rx, run_tx, irq_out;
  int          n_vec = 0, n_bad = 0;

  always #10 clk = ~clk;

  iacsr_top i_iacsr_top (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_off(bus_off), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_done(rx_done), .tx_done(tx_done), .tx_babble(tx_babble),
    .run_rx(run_rx), .run_tx(run_tx), .irq_out(irq_out)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] off, logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_off = off; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(logic [1:0] off, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_off = off;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rd_csr0(output logic [15:0] d);
    bus_rd(2'd0, d);
  endtask

  task automatic pulse(logic rx, logic tx, logic bab);
    @(negedge clk);
    rx_done = rx; tx_done = tx; tx_babble = bab;
    @(negedge clk);
    rx_done = 1'b0; tx_done = 1'b0; tx_babble = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd_csr0(v);       check("R10 csr0 after reset", v, 16'h0004);
    bus_rd(2'd1, v);  check("R10 pointer after reset", v, 16'h0000);
    check("R10 irq after reset", {15'd0, irq_out}, 16'h0000);
    bus_wr(2'd1, 16'd1); bus_rd(2'd0, v);
    check("R10 storage after reset", v, 16'h0000);
    bus_wr(2'd1, 16'd0);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    bus_wr(2'd1, 16'd3); bus_rd(2'd1, v); check("R1 pointer readback", v, 16'd3);
    bus_wr(2'd1, 16'd2); bus_wr(2'd0, 16'hBEEF);
    bus_wr(2'd1, 16'd3); bus_wr(2'd0, 16'h1234);
    bus_wr(2'd1, 16'd2); bus_rd(2'd0, v); check("R1 reg2 via window", v, 16'hBEEF);
    bus_wr(2'd1, 16'd3); bus_rd(2'd0, v); check("R9 reg3 storage", v, 16'h1234);
    bus_wr(2'd1, 16'd9); bus_wr(2'd0, 16'hFFFF);
    bus_rd(2'd0, v); check("R9 out-of-range window", v, 16'h0000);
    bus_wr(2'd1, 16'd2); bus_rd(2'd0, v); check("R9 out-of-range no alias", v, 16'hBEEF);
    bus_wr(2'd1, 16'd0); rd_csr0(v); check("R9 csr0 untouched", v, 16'h0004);
  endtask

  task automatic t_init();
    logic [15:0] v;
    bus_wr(2'd0, 16'h0041); rd_csr0(v);
    check("R3 init sets INIT IDON clears STOP", v, 16'h01C1);
    check("R6 irq with INEA and IDON", {15'd0, irq_out}, 16'h0001);
    bus_wr(2'd0, 16'h0140); rd_csr0(v);
    check("R7 w1c IDON keeps INIT", v, 16'h0041);
    check("R6 irq low with nothing pending", {15'd0, irq_out}, 16'h0000);
  endtask

  task automatic t_start();
    logic [15:0] v;
    bus_wr(2'd0, 16'h0042); rd_csr0(v);
    check("R4 start sets START RXON TXON", v, 16'h0073);
    check("R4 run outputs", {14'd0, run_rx, run_tx}, 16'h0003);
  endtask

  task automatic t_events();
    logic [15:0] v;
    pulse(1'b1, 1'b0, 1'b0); rd_csr0(v);
    check("R5 rx sets RINT INTR", v, 16'h04F3);
    check("R6 irq after rx", {15'd0, irq_out}, 16'h0001);
    pulse(1'b0, 1'b1, 1'b0); rd_csr0(v);
    check("R5 tx sets TINT", v, 16'h06F3);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_off = 2'd0; bus_wdata = 16'h0440; rx_done = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; rx_done = 1'b0;
    rd_csr0(v); check("R5 event beats same-cycle clear", v, 16'h06F3);
    bus_wr(2'd0, 16'h0640); rd_csr0(v);
    check("R7 w1c RINT TINT", v, 16'h0073);
    check("R6 irq cleared", {15'd0, irq_out}, 16'h0000);
  endtask

  task automatic t_babble();
    logic [15:0] v;
    pulse(1'b0, 1'b0, 1'b1); rd_csr0(v);
    check("R8 babble sets BABL ERR INTR", v, 16'hC0F3);
    bus_wr(2'd0, 16'h4040); rd_csr0(v);
    check("R8 ERR follows BABL clear", v, 16'h0073);
  endtask

  task automatic t_undef();
    logic [15:0] v;
    bus_wr(2'd2, 16'h0007); bus_wr(2'd3, 16'h0005);
    bus_rd(2'd2, v); check("R9 offset 2 reads zero", v, 16'h0000);
    bus_rd(2'd3, v); check("R9 offset 3 reads zero", v, 16'h0000);
    bus_rd(2'd1, v); check("R9 pointer unchanged", v, 16'h0000);
    rd_csr0(v);      check("R9 csr0 unchanged", v, 16'h0073);
  endtask

  task automatic t_inea_off();
    logic [15:0] v;
    bus_wr(2'd0, 16'h0000); rd_csr0(v);
    check("R7 zero write keeps command bits", v, 16'h0033);
    pulse(1'b1, 1'b0, 1'b0); rd_csr0(v);
    check("R6 flag pending without enable", v, 16'h04B3);
    check("R6 irq gated by INEA", {15'd0, irq_out}, 16'h0000);
    bus_wr(2'd0, 16'h0400); rd_csr0(v);
    check("R7 w1c with INEA clear", v, 16'h0033);
  endtask

  task automatic t_priority();
    logic [15:0] v;
    bus_wr(2'd0, 16'h0007); rd_csr0(v);
    check("R2 stop beats init and start", v, 16'h0004);
    check("R4 run outputs off after stop", {14'd0, run_rx, run_tx}, 16'h0000);
    bus_wr(2'd0, 16'h0003); rd_csr0(v);
    check("R3 init beats start", v, 16'h0181);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_off = 2'd0; bus_wdata = 16'h0004;
    rx_done = 1'b1; tx_babble = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; rx_done = 1'b0; tx_babble = 1'b0;
    rd_csr0(v); check("R2 stop drops same-cycle events", v, 16'h0004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_init();
    t_start();
    t_events();
    t_babble();
    t_undef();
    t_inea_off();
    t_priority();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule